// File: doc/BRIEF.md
# Exclusive Two-Level Cache Tag Controller

This block keeps the tags and the replacement state of a small two-way first-level data cache and the sixteen-way second-level cache behind it. The two levels are exclusive: a line is held by at most one of them. Line data is not stored here. Each line is named by its line address (the request address without the byte offset within the 64-byte line). A datapath that holds the actual bytes can follow the status outputs of this block.

A load request is accepted on a valid/ready handshake. A first-level hit answers one cycle later. A second-level hit swaps the two lines. The requested line moves up into the first level, and the first-level victim is written down into the second level. This moves two lines across the path between the levels. When both levels miss, the block asks memory for the line, places the fill directly in the first level, and pushes the first-level victim down. If the target second-level set is full, that push evicts the least recently used line of the set.

Only one miss is handled at a time. The requester sees the level that supplied each line, and the status outputs report every line moved down and every line dropped.

Top module: `excl_cache_ctl`

## Requirements
- R1: After reset both levels are empty, reqReady is 1, and busy, respValid and memReqValid are 0. The first access to any line is served from memory.
- R2: A first-level hit gives respValid with respLevel = 1 exactly one cycle after the request is accepted. No memory request and no write-down happens.
- R3: A second-level hit gives respValid with respLevel = 2 exactly two cycles after acceptance. busy is 1 in that cycle and memReqValid is 0.
- R4: On a second-level hit with a valid victim in the first-level set, xferValid is 1 in the response cycle and xferLine is the victim line. Afterwards the promoted line is held only in the first level.
- R5: When both levels miss, memReqValid rises with memReqLine equal to the requested line address. It and memReqLine stay unchanged until memFillValid. The response has respLevel = 3 in the cycle memFillValid is high, and busy is 1 while waiting.
- R6: Levels are exclusive. A line brought in from the second level or from memory is placed in the first level only. A later access to it hits the first level until it is evicted. Neither xferLine nor dropLine is ever the requested line.
- R7: The first-level victim is the lowest-numbered invalid way of the set, or the least recently used way when both ways are valid. Hits and fills both count as use.
- R8: A line moved down goes to the set selected by its line address modulo the second-level set count. If that set is full, its least recently used line is dropped and reported with dropValid and dropLine in the same cycle. Otherwise nothing is dropped.
- R9: Address bits [5:0] select a byte within the 64-byte line and do not affect lookup. Two addresses that differ only there name the same line.
- R10: When a second-level hit frees a way in the same set that the first-level victim maps to, the victim takes the freed way, and dropValid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Load request present |
| reqReady | output | 1 | Block idle and able to accept a request |
| reqAddr | input | ADDR_W | Byte address of the load |
| respValid | output | 1 | Request completes this cycle |
| respLevel | output | 2 | Supplying level: 1 first level, 2 second level, 3 memory |
| busy | output | 1 | A swap or a memory fill is in progress |
| memReqValid | output | 1 | Line fetch request to memory |
| memReqLine | output | ADDR_W-6 | Line address to fetch |
| memFillValid | input | 1 | Memory returns the requested line this cycle |
| xferValid | output | 1 | A first-level victim is written into the second level this cycle |
| xferLine | output | ADDR_W-6 | Line address of that victim |
| dropValid | output | 1 | A second-level line is evicted from the hierarchy this cycle |
| dropLine | output | ADDR_W-6 | Line address of the evicted line |

## Verification
The bench uses five access patterns:
- A forward sweep over many more lines than both levels hold. It causes memory misses everywhere, fills every second-level set, and forces least-recently-used drops.
- A backward sweep over the same lines. It hits recently pushed lines in the second level, which shows the swap and the write-down, and separates true recency order from fill order.
- A small loop that fits in the first level. It shows single-cycle hits and the first-level replacement.
- A long pseudo-random stream with random byte offsets. It mixes all three levels with same-set swaps, which shows that offset bits are ignored and that a freed way is reused.
- A pair of accesses to opposite ends of one line.

Every response is compared in level, latency, write-down line and dropped line against a recency model kept in the bench.

// File: rtl/excl_cache_pkg.sv
`timescale 1ns/1ps
package excl_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_SWAP,
    ST_MISS
  } ctrlState_e;

  // Strobes from the control FSM to the tag datapath.
  typedef struct packed {
    logic captureReq;
    logic l1Touch;
    logic doSwap;
    logic doFill;
  } dpStrobe_t;

  localparam logic [1:0] LVL_L1  = 2'd1;
  localparam logic [1:0] LVL_L2  = 2'd2;
  localparam logic [1:0] LVL_MEM = 2'd3;

endpackage

// File: rtl/excl_cache_dp.sv
`timescale 1ns/1ps
module excl_cache_dp
  import excl_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int L1_SETS    = 4,
  parameter int L2_SETS    = 8,
  parameter int L2_WAYS    = 16
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  dpStrobe_t                             strobe,
  input  logic [ADDR_W-1:0]                     reqAddr,
  output logic                                  l1Hit,
  output logic                                  l2Hit,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  reqLine,
  output logic                                  xferValid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  xferLine,
  output logic                                  dropValid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  dropLine
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LA_W   = ADDR_W - OFF_W;
  localparam int L1_IW  = $clog2(L1_SETS);
  localparam int L2_IW  = $clog2(L2_SETS);
  localparam int L1_TW  = LA_W - L1_IW;
  localparam int L2_TW  = LA_W - L2_IW;
  localparam int WAY2_W = $clog2(L2_WAYS);
  localparam logic [WAY2_W-1:0] AGE_OLDEST = WAY2_W'(L2_WAYS - 1);

  // First level: two ways, one bit per set naming the way to evict.
  logic             l1Valid [L1_SETS][2];
  logic [L1_TW-1:0] l1Tag   [L1_SETS][2];
  logic             l1Lru   [L1_SETS];

  // Second level: recency rank per way, 0 = most recent.
  logic              l2Valid [L2_SETS][L2_WAYS];
  logic [L2_TW-1:0]  l2Tag   [L2_SETS][L2_WAYS];
  logic [WAY2_W-1:0] l2Age   [L2_SETS][L2_WAYS];

  logic [L1_IW-1:0]  l1Idx;
  logic [L1_TW-1:0]  l1TagQ;
  logic [L2_IW-1:0]  l2Idx;
  logic [L2_TW-1:0]  l2TagQ;
  logic              l1HitWay;
  logic [WAY2_W-1:0] l2HitWay;

  logic              vWay;
  logic              vValid;
  logic [LA_W-1:0]   vLine;
  logic [L2_IW-1:0]  vIdx;
  logic [L2_TW-1:0]  vTag;
  logic              sameSet;
  logic              anyFree;
  logic [WAY2_W-1:0] freeWay;
  logic [WAY2_W-1:0] lruWay;
  logic [WAY2_W-1:0] tWay;
  logic              moving;

  assign l1Idx  = reqLine[L1_IW-1:0];
  assign l1TagQ = reqLine[LA_W-1:L1_IW];
  assign l2Idx  = reqLine[L2_IW-1:0];
  assign l2TagQ = reqLine[LA_W-1:L2_IW];
  assign moving = strobe.doSwap | strobe.doFill;

  // Lookup in both levels.
  always_comb begin
    l1Hit    = 1'b0;
    l1HitWay = 1'b0;
    for (int w = 0; w < 2; w++) begin
      if (l1Valid[l1Idx][w] && l1Tag[l1Idx][w] == l1TagQ) begin
        l1Hit    = 1'b1;
        l1HitWay = 1'(w);
      end
    end
    l2Hit    = 1'b0;
    l2HitWay = '0;
    for (int w = 0; w < L2_WAYS; w++) begin
      if (l2Valid[l2Idx][w] && l2Tag[l2Idx][w] == l2TagQ) begin
        l2Hit    = 1'b1;
        l2HitWay = WAY2_W'(w);
      end
    end
  end

  // First-level victim and its destination in the second level.
  always_comb begin
    if (!l1Valid[l1Idx][0])      vWay = 1'b0;
    else if (!l1Valid[l1Idx][1]) vWay = 1'b1;
    else                         vWay = l1Lru[l1Idx];
    vValid  = l1Valid[l1Idx][vWay];
    vLine   = {l1Tag[l1Idx][vWay], l1Idx};
    vIdx    = vLine[L2_IW-1:0];
    vTag    = vLine[LA_W-1:L2_IW];
    sameSet = l2Hit && (vIdx == l2Idx);
    anyFree = 1'b0;
    freeWay = '0;
    lruWay  = '0;
    for (int w = L2_WAYS - 1; w >= 0; w--) begin
      if (!l2Valid[vIdx][w] || (sameSet && l2HitWay == WAY2_W'(w))) begin
        anyFree = 1'b1;
        freeWay = WAY2_W'(w);
      end
      if (l2Age[vIdx][w] == AGE_OLDEST) lruWay = WAY2_W'(w);
    end
    if (sameSet)      tWay = l2HitWay;
    else if (anyFree) tWay = freeWay;
    else              tWay = lruWay;
  end

  assign xferValid = moving && vValid;
  assign xferLine  = vLine;
  assign dropValid = xferValid && !anyFree;
  assign dropLine  = {l2Tag[vIdx][tWay], vIdx};

  // Valid bits and replacement state.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqLine <= '0;
      for (int s = 0; s < L1_SETS; s++) begin
        l1Lru[s] <= 1'b0;
        for (int w = 0; w < 2; w++) l1Valid[s][w] <= 1'b0;
      end
      for (int s = 0; s < L2_SETS; s++) begin
        for (int w = 0; w < L2_WAYS; w++) begin
          l2Valid[s][w] <= 1'b0;
          l2Age[s][w]   <= WAY2_W'(w);
        end
      end
    end else begin
      if (strobe.captureReq) reqLine <= reqAddr[ADDR_W-1:OFF_W];
      if (strobe.l1Touch) l1Lru[l1Idx] <= ~l1HitWay;
      if (moving) begin
        l1Valid[l1Idx][vWay] <= 1'b1;
        l1Lru[l1Idx]         <= ~vWay;
        if (strobe.doSwap) l2Valid[l2Idx][l2HitWay] <= 1'b0;
        if (vValid) begin
          l2Valid[vIdx][tWay] <= 1'b1;
          for (int w = 0; w < L2_WAYS; w++) begin
            if (WAY2_W'(w) == tWay)
              l2Age[vIdx][w] <= '0;
            else if (l2Age[vIdx][w] < l2Age[vIdx][tWay])
              l2Age[vIdx][w] <= l2Age[vIdx][w] + 1'b1;
          end
        end
      end
    end
  end

  // Tag storage needs no reset: valid bits gate it.
  always_ff @(posedge clk) begin
    if (moving) begin
      l1Tag[l1Idx][vWay] <= l1TagQ;
      if (vValid) l2Tag[vIdx][tWay] <= vTag;
    end
  end

endmodule

// File: rtl/excl_cache_ctrl.sv
`timescale 1ns/1ps
module excl_cache_ctrl
  import excl_cache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       l1Hit,
  input  logic       l2Hit,
  input  logic       memFillValid,
  output logic       reqReady,
  output logic       busy,
  output logic       respValid,
  output logic [1:0] respLevel,
  output logic       memReqValid,
  output dpStrobe_t  strobe
);

  ctrlState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    reqReady    = 1'b0;
    busy        = 1'b0;
    respValid   = 1'b0;
    respLevel   = 2'd0;
    memReqValid = 1'b0;
    strobe      = '0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.captureReq = 1'b1;
          nextState         = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (l1Hit) begin
          respValid      = 1'b1;
          respLevel      = LVL_L1;
          strobe.l1Touch = 1'b1;
          nextState      = ST_IDLE;
        end else if (l2Hit) begin
          nextState = ST_SWAP;
        end else begin
          nextState = ST_MISS;
        end
      end
      ST_SWAP: begin
        busy          = 1'b1;
        respValid     = 1'b1;
        respLevel     = LVL_L2;
        strobe.doSwap = 1'b1;
        nextState     = ST_IDLE;
      end
      ST_MISS: begin
        busy        = 1'b1;
        memReqValid = 1'b1;
        if (memFillValid) begin
          respValid     = 1'b1;
          respLevel     = LVL_MEM;
          strobe.doFill = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/excl_cache_ctl.sv
`timescale 1ns/1ps
module excl_cache_ctl
  import excl_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int L1_SETS    = 4,
  parameter int L2_SETS    = 8,
  parameter int L2_WAYS    = 16
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  reqValid,
  output logic                                  reqReady,
  input  logic [ADDR_W-1:0]                     reqAddr,
  output logic                                  respValid,
  output logic [1:0]                            respLevel,
  output logic                                  busy,
  output logic                                  memReqValid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  memReqLine,
  input  logic                                  memFillValid,
  output logic                                  xferValid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  xferLine,
  output logic                                  dropValid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  dropLine
);

  dpStrobe_t strobe;
  logic      l1Hit;
  logic      l2Hit;

  excl_cache_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .l1Hit        (l1Hit),
    .l2Hit        (l2Hit),
    .memFillValid (memFillValid),
    .reqReady     (reqReady),
    .busy         (busy),
    .respValid    (respValid),
    .respLevel    (respLevel),
    .memReqValid  (memReqValid),
    .strobe       (strobe)
  );

  excl_cache_dp #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .L1_SETS    (L1_SETS),
    .L2_SETS    (L2_SETS),
    .L2_WAYS    (L2_WAYS)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .l1Hit     (l1Hit),
    .l2Hit     (l2Hit),
    .reqLine   (memReqLine),
    .xferValid (xferValid),
    .xferLine  (xferLine),
    .dropValid (dropValid),
    .dropLine  (dropLine)
  );

endmodule

// File: rtl/excl_cache_ctl_chk.sv
`timescale 1ns/1ps
module excl_cache_ctl_chk
  import excl_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int L2_SETS    = 8
) (
  input logic                                  clk,
  input logic                                  rstN,
  input logic                                  reqValid,
  input logic                                  reqReady,
  input logic [ADDR_W-1:0]                     reqAddr,
  input logic                                  respValid,
  input logic [1:0]                            respLevel,
  input logic                                  busy,
  input logic                                  memReqValid,
  input logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  memReqLine,
  input logic                                  memFillValid,
  input logic                                  xferValid,
  input logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  xferLine,
  input logic                                  dropValid,
  input logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  dropLine
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int LA_W  = ADDR_W - OFF_W;
  localparam int L2_IW = $clog2(L2_SETS);

  logic [LA_W-1:0] acceptLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acceptLine <= '0;
    else if (reqValid && reqReady) acceptLine <= reqAddr[ADDR_W-1:OFF_W];
  end

  a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!busy && !respValid && !memReqValid));

  a_r2_l1_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respLevel == LVL_L1) |-> ($past(reqValid && reqReady) && !xferValid));

  a_r3_l2_busy: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respLevel == LVL_L2) |-> (busy && !memReqValid));

  a_r4_xfer_on_move: assert property (@(posedge clk) disable iff (!rstN)
    xferValid |-> (respValid && respLevel != LVL_L1));

  a_r5_mem_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memFillValid) |=> (memReqValid && $stable(memReqLine)));

  a_r5_mem_line: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqLine == acceptLine));

  a_r6_exclusive_xfer: assert property (@(posedge clk) disable iff (!rstN)
    xferValid |-> (xferLine != acceptLine));

  a_r6_exclusive_drop: assert property (@(posedge clk) disable iff (!rstN)
    dropValid |-> (dropLine != acceptLine));

  a_r8_drop_with_xfer: assert property (@(posedge clk) disable iff (!rstN)
    dropValid |-> (xferValid && dropLine[L2_IW-1:0] == xferLine[L2_IW-1:0]));

  a_r10_freed_way_reuse: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respLevel == LVL_L2 && xferValid &&
     xferLine[L2_IW-1:0] == acceptLine[L2_IW-1:0]) |-> !dropValid);

endmodule

bind excl_cache_ctl excl_cache_ctl_chk #(
  .ADDR_W     (ADDR_W),
  .LINE_BYTES (LINE_BYTES),
  .L2_SETS    (L2_SETS)
) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .reqAddr      (reqAddr),
  .respValid    (respValid),
  .respLevel    (respLevel),
  .busy         (busy),
  .memReqValid  (memReqValid),
  .memReqLine   (memReqLine),
  .memFillValid (memFillValid),
  .xferValid    (xferValid),
  .xferLine     (xferLine),
  .dropValid    (dropValid),
  .dropLine     (dropLine)
);

// File: tb/sim_excl_cache_ctl.sv
`timescale 1ns/1ps
module sim_excl_cache_ctl;

  localparam int ADDR_W  = 32;
  localparam int OFF_W   = 6;
  localparam int LA_W    = ADDR_W - OFF_W;
  localparam int L1S     = 4;
  localparam int L2S     = 8;
  localparam int L2W     = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic            reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic            respValid;
  logic [1:0]      respLevel;
  logic            busy;
  logic            memReqValid;
  logic [LA_W-1:0] memReqLine;
  logic            memFillValid = 1'b0;
  logic            xferValid;
  logic [LA_W-1:0] xferLine;
  logic            dropValid;
  logic [LA_W-1:0] dropLine;

  always #2 clk = ~clk;

  excl_cache_ctl #(
    .ADDR_W(ADDR_W), .LINE_BYTES(64), .L1_SETS(L1S), .L2_SETS(L2S), .L2_WAYS(L2W)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .respValid(respValid), .respLevel(respLevel), .busy(busy),
    .memReqValid(memReqValid), .memReqLine(memReqLine), .memFillValid(memFillValid),
    .xferValid(xferValid), .xferLine(xferLine), .dropValid(dropValid), .dropLine(dropLine)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // Recency model: higher stamp = more recently used.
  bit m1V [L1S][2];
  int m1L [L1S][2];
  int m1S [L1S][2];
  bit m2V [L2S][L2W];
  int m2L [L2S][L2W];
  int m2S [L2S][L2W];
  int tick = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int s = 0; s < L1S; s++)
      for (int w = 0; w < 2; w++) begin m1V[s][w] = 0; m1S[s][w] = -1 - w; end
    for (int s = 0; s < L2S; s++)
      for (int w = 0; w < L2W; w++) begin m2V[s][w] = 0; m2S[s][w] = -1 - w; end
  endtask

  task automatic modelAccess(int line, output int lvl, output bit xv, output int xl,
                             output bit dv, output int dl);
    int s1 = line % L1S;
    int s2 = line % L2S;
    int h2 = -1;
    int vw;
    xv = 0; xl = 0; dv = 0; dl = 0;
    for (int w = 0; w < 2; w++)
      if (m1V[s1][w] && m1L[s1][w] == line) begin
        lvl = 1; m1S[s1][w] = ++tick; return;
      end
    for (int w = 0; w < L2W; w++)
      if (m2V[s2][w] && m2L[s2][w] == line) h2 = w;
    lvl = (h2 >= 0) ? 2 : 3;
    // R7: lowest invalid way, else least recent
    if (!m1V[s1][0]) vw = 0;
    else if (!m1V[s1][1]) vw = 1;
    else vw = (m1S[s1][0] < m1S[s1][1]) ? 0 : 1;
    xv = m1V[s1][vw];
    xl = m1L[s1][vw];
    if (h2 >= 0) m2V[s2][h2] = 0;
    m1V[s1][vw] = 1; m1L[s1][vw] = line; m1S[s1][vw] = ++tick;
    if (xv) begin
      int vs = xl % L2S;
      int tw = -1;
      if (h2 >= 0 && vs == s2) tw = h2;      // R10
      else begin
        for (int w = L2W - 1; w >= 0; w--) if (!m2V[vs][w]) tw = w;
        if (tw < 0) begin                   // R8: full set, drop least recent
          tw = 0;
          for (int w = 1; w < L2W; w++) if (m2S[vs][w] < m2S[vs][tw]) tw = w;
          dv = 1; dl = m2L[vs][tw];
        end
      end
      m2V[vs][tw] = 1; m2L[vs][tw] = xl; m2S[vs][tw] = ++tick;
    end
  endtask

  task automatic access(int line, int offs);
    int expLvl, expXl, expDl, lat, memWait;
    bit expXv, expDv, memSeen, lineOk, busyOk;
    modelAccess(line, expLvl, expXv, expXl, expDv, expDl);
    @(negedge clk);
    chk(reqReady, "R1 ready when idle", int'(reqReady), 1);
    reqAddr  = {LA_W'(line), OFF_W'(offs)};
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1; memWait = 0; memSeen = 0; lineOk = 1; busyOk = 1;
    while (!respValid && lat < 60) begin
      if (memReqValid) begin
        memSeen = 1;
        if (memReqLine != LA_W'(line)) lineOk = 0;
        if (!busy) busyOk = 0;
        if (memWait == 2) begin memFillValid = 1'b1; #1; end
        else memWait++;
      end
      if (!respValid) begin @(negedge clk); lat++; end
    end
    chk(respValid && int'(respLevel) == expLvl, "R2/R3/R5 level", int'(respLevel), expLvl);
    if (expLvl == 1) chk(lat == 1 && !memSeen, "R2 first-level hit latency", lat, 1);
    if (expLvl == 2) chk(lat == 2 && busy && !memSeen, "R3 second-level hit latency", lat, 2);
    if (expLvl == 3) chk(memSeen && lineOk && busyOk, "R5 memory request line", int'(memReqLine), line);
    chk(xferValid == expXv, "R4 write-down flag", int'(xferValid), int'(expXv));
    if (expXv) chk(int'(xferLine) == expXl, "R4 R7 write-down line", int'(xferLine), expXl);
    chk(dropValid == expDv, "R8 R10 drop flag", int'(dropValid), int'(expDv));
    if (expDv) chk(int'(dropLine) == expDl, "R8 dropped line", int'(dropLine), expDl);
    @(posedge clk);
    #1 memFillValid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    nFails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int lfsr;
    int expLvl, xl, dl;
    bit xv, dv;
    modelReset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(reqReady == 1'b1, "R1 reqReady in reset", int'(reqReady), 1);
    chk(!busy && !respValid && !memReqValid, "R1 idle outputs in reset", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !busy, "R1 ready after reset", int'(reqReady), 1);

    // Forward sweep: all misses, fills every set, forces drops (R5 R6 R8)
    for (int i = 0; i < 200; i++) access(i, 0);
    // Backward sweep: second-level hits and swaps (R3 R4 R10)
    for (int i = 199; i >= 0; i--) access(i, 4);
    // Small loop fitting the first level: single-cycle hits (R2 R7)
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < 8; i++) access(i, 8 * r);
    // R6: a line fetched from memory then hits the first level
    modelAccess(1000, expLvl, xv, xl, dv, dl);
    modelReset();
    tick = 0;
    // restart with a fresh reset to also show R1 again
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    access(1000, 0);
    // R9: the far end of the same 64-byte line hits the first level
    access(1000, 63);
    access(1000, 17);
    // Pseudo-random stream with random offsets (R9 R10 mixes)
    lfsr = 32'h1ace;
    for (int i = 0; i < 1500; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h0000b400 : 0);
      access(lfsr % 224, (lfsr >> 8) % 64);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule